// File: doc/BRIEF.md
# Elevator Car Motion and Door Controller

This block sequences one elevator car. It is given the floor the car should serve and the floor the car is at now, both as unsigned numbers. It drives four outputs: move up, move down, door open, and dwell start. When the target lies above the car it commands upward travel, and when the target lies below it commands downward travel. When the car reaches or passes the target, the block opens the door and holds it open for a minimum number of seconds before it returns to rest.

The door dwell is counted inside the block from a one-cycle tick that arrives once per second. The counter runs only while the door-dwell state is active. It is held at zero at all other times, and it saturates rather than wrapping. The state is a registered four-state Moore machine. Every output is decoded from the registered state alone, so no output changes except on a clock edge.

Top module: `lift_car_ctrl`

## Requirements
- R1: While rst_n is low the machine is forced to rest at once, without waiting for a clock edge. At rest the outputs are {move_up,move_dn,door_open,dwell_start} = 0010.
- R2: Each state drives one fixed pattern of {move_up,move_dn,door_open,dwell_start}: rest 0010, rising 1000, falling 0100, dwell 0011. move_up and move_dn are never high together, and dwell_start is never high without door_open.
- R3: At rest, a clock edge moves to rising when target_flr > cur_flr and to falling when target_flr < cur_flr. When the two are equal, the machine stays at rest.
- R4: While rising, the machine stays rising as long as target_flr > cur_flr. On the first edge where that no longer holds, including an overshoot, it moves to dwell.
- R5: While falling, the machine stays falling as long as target_flr < cur_flr. On the first edge where that no longer holds, including an overshoot, it moves to dwell.
- R6: In dwell the machine ignores target_flr and cur_flr. It leaves dwell for rest on the first clock edge after DWELL_SEC (default 10) sec_tick pulses have been counted in dwell. Until then it stays in dwell, and edges without a tick leave the count unchanged.
- R7: sec_tick pulses outside dwell, including one present on the edge that enters dwell, add nothing to the dwell count.
- R8: door_open is never high while move_up or move_dn is high.
- R9: A change of target_flr or cur_flr between clock edges leaves every output unchanged until the next rising edge.
- R10: target_flr and cur_flr are compared as unsigned FLOOR_W-bit numbers. With FLOOR_W = 4, a target of 15 lies above a floor of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse once per second |
| target_flr | input | FLOOR_W | Floor the car must serve |
| cur_flr | input | FLOOR_W | Floor the car is at now |
| move_up | output | 1 | Command upward travel |
| move_dn | output | 1 | Command downward travel |
| door_open | output | 1 | Command the door open |
| dwell_start | output | 1 | High while the dwell timer is running |

## Verification
Every output pattern is due one rising edge after the inputs that select it. The bench drives inputs 2 ns after an edge and reads the outputs 2 ns after the following edge, so each vector sees exactly one register stage. The return to rest is due on the edge after the one that registers the DWELL_SEC-th counted tick, and the vector table counts that edge explicitly, with tick-free edges placed at the threshold. Reset is checked a few nanoseconds into the low pulse, before any edge, and the check of mid-cycle input changes samples between edges.

// File: rtl/lift_pkg.sv
package lift_pkg;

    typedef enum logic [1:0] {
        ST_REST  = 2'd0,
        ST_RISE  = 2'd1,
        ST_FALL  = 2'd2,
        ST_DWELL = 2'd3
    } car_state_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic open;
        logic start;
    } car_out_t;

    typedef struct packed {
        car_state_e st;
    } car_regs_t;

endpackage

// File: rtl/lift_floor_cmp.sv
module lift_floor_cmp #(
    parameter int FLOOR_W = 4
) (
    input  logic [FLOOR_W-1:0] tgt,
    input  logic [FLOOR_W-1:0] cur,
    output logic               above,
    output logic               below
);
    // unsigned magnitude compare of target against present floor
    always_comb begin
        above = (tgt > cur);
        below = (tgt < cur);
    end
endmodule

// File: rtl/lift_dwell_timer.sv
module lift_dwell_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/lift_out_decode.sv
module lift_out_decode
    import lift_pkg::*;
(
    input  car_state_e st,
    output car_out_t   outs
);
    always_comb begin
        outs = '{up: 1'b0, dn: 1'b0, open: 1'b0, start: 1'b0};
        unique case (st)
            ST_REST:  outs.open  = 1'b1;
            ST_RISE:  outs.up    = 1'b1;
            ST_FALL:  outs.dn    = 1'b1;
            ST_DWELL: begin
                outs.open  = 1'b1;
                outs.start = 1'b1;
            end
            default:  outs.open  = 1'b1;
        endcase
    end
endmodule

// File: rtl/lift_car_ctrl.sv
module lift_car_ctrl
    import lift_pkg::*;
#(
    parameter int FLOOR_W   = 4,
    parameter int DWELL_SEC = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_tick,
    input  logic [FLOOR_W-1:0] target_flr,
    input  logic [FLOOR_W-1:0] cur_flr,
    output logic               move_up,
    output logic               move_dn,
    output logic               door_open,
    output logic               dwell_start
);
    localparam int              TMR_W     = $clog2(DWELL_SEC + 1);
    localparam logic [TMR_W-1:0] DWELL_LIM = TMR_W'(DWELL_SEC);

    car_regs_t        regs_d, regs_q;
    car_out_t         outs;
    logic             tgt_above, tgt_below;
    logic [TMR_W-1:0] dwell_cnt;
    logic             dwell_done;

    lift_floor_cmp #(.FLOOR_W(FLOOR_W)) u_cmp (
        .tgt   (target_flr),
        .cur   (cur_flr),
        .above (tgt_above),
        .below (tgt_below)
    );

    lift_dwell_timer #(.CNT_W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (outs.start),
        .tick  (sec_tick),
        .count (dwell_cnt)
    );

    assign dwell_done = (dwell_cnt >= DWELL_LIM);

    // next-state: each state's exits are disjoint and cover all inputs
    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_REST: begin
                if (tgt_above)      regs_d.st = ST_RISE;
                else if (tgt_below) regs_d.st = ST_FALL;
                else                regs_d.st = ST_REST;
            end
            ST_RISE:  regs_d.st = tgt_above  ? ST_RISE : ST_DWELL;
            ST_FALL:  regs_d.st = tgt_below  ? ST_FALL : ST_DWELL;
            ST_DWELL: regs_d.st = dwell_done ? ST_REST : ST_DWELL;
            default:  regs_d.st = ST_REST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_REST};
        end else begin
            regs_q <= regs_d;
        end
    end

    lift_out_decode u_dec (
        .st   (regs_q.st),
        .outs (outs)
    );

    assign move_up     = outs.up;
    assign move_dn     = outs.dn;
    assign door_open   = outs.open;
    assign dwell_start = outs.start;
endmodule

// File: rtl/lift_car_ctrl_chk.sv
module lift_car_ctrl_chk #(
    parameter int FLOOR_W   = 4,
    parameter int DWELL_SEC = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sec_tick,
    input logic [FLOOR_W-1:0] target_flr,
    input logic [FLOOR_W-1:0] cur_flr,
    input logic               move_up,
    input logic               move_dn,
    input logic               door_open,
    input logic               dwell_start
);
    localparam int            SW    = $clog2(DWELL_SEC + 1) + 1;
    localparam logic [SW-1:0] S_LIM = SW'(DWELL_SEC);
    localparam logic [SW-1:0] S_MAX = {SW{1'b1}};

    // ticks seen since the door-dwell pattern began
    logic [SW-1:0] seen_q;
    logic          at_rest;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (!dwell_start) begin
            seen_q <= '0;
        end else if (sec_tick && (seen_q != S_MAX)) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    assign at_rest = door_open && !dwell_start && !move_up && !move_dn;

    AST_DOOR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        door_open |-> !(move_up || move_dn));                               // R8
    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(move_up && move_dn));                                             // R2
    AST_START_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        dwell_start |-> door_open);                                         // R2
    AST_REST_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_rest && (target_flr > cur_flr)) |=> move_up);                   // R3
    AST_REST_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (at_rest && (target_flr < cur_flr)) |=> move_dn);                   // R3
    AST_REST_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (at_rest && (target_flr == cur_flr)) |=> at_rest);                  // R3
    AST_UP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (move_up && (target_flr > cur_flr)) |=> move_up);                   // R4
    AST_UP_ARRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (move_up && !(target_flr > cur_flr)) |=> dwell_start);              // R4
    AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (move_dn && (target_flr < cur_flr)) |=> move_dn);                   // R5
    AST_DN_ARRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (move_dn && !(target_flr < cur_flr)) |=> dwell_start);              // R5
    AST_DWELL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (dwell_start && (seen_q < S_LIM)) |=> dwell_start);                 // R6
    AST_DWELL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dwell_start && (seen_q >= S_LIM)) |=> at_rest);                    // R6
endmodule

bind lift_car_ctrl lift_car_ctrl_chk #(
    .FLOOR_W   (FLOOR_W),
    .DWELL_SEC (DWELL_SEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .target_flr  (target_flr),
    .cur_flr     (cur_flr),
    .move_up     (move_up),
    .move_dn     (move_dn),
    .door_open   (door_open),
    .dwell_start (dwell_start)
);

// File: tb/lift_car_ctrl_test.sv
module lift_car_ctrl_test;
    localparam logic [3:0] P_REST  = 4'b0010;
    localparam logic [3:0] P_RISE  = 4'b1000;
    localparam logic [3:0] P_FALL  = 4'b0100;
    localparam logic [3:0] P_DWELL = 4'b0011;

    // {target[4], floor[4], tick[1], edges[4], expected pattern[4]}
    localparam int NVEC = 21;
    localparam logic [16:0] VEC [NVEC] = '{
        {4'd3,  4'd3,  1'b0, 4'd1,  P_REST },  // R3 equal, stay at rest
        {4'd15, 4'd0,  1'b0, 4'd1,  P_RISE },  // R10 unsigned 15 above 0
        {4'd15, 4'd14, 1'b0, 4'd2,  P_RISE },  // R4 still below target
        {4'd15, 4'd15, 1'b0, 4'd1,  P_DWELL},  // R4 arrival
        {4'd0,  4'd9,  1'b1, 4'd10, P_DWELL},  // R6 ten ticks, inputs ignored
        {4'd0,  4'd9,  1'b0, 4'd1,  P_REST },  // R6 exit edge after 10th tick
        {4'd0,  4'd9,  1'b0, 4'd1,  P_FALL },  // R3 target below
        {4'd0,  4'd5,  1'b0, 4'd3,  P_FALL },  // R5 hold
        {4'd6,  4'd5,  1'b0, 4'd1,  P_DWELL},  // R5 overshoot
        {4'd6,  4'd5,  1'b1, 4'd9,  P_DWELL},  // R6 nine ticks
        {4'd6,  4'd5,  1'b0, 4'd2,  P_DWELL},  // R6 no tick, count holds at 9
        {4'd6,  4'd5,  1'b1, 4'd1,  P_DWELL},  // R6 tenth tick
        {4'd6,  4'd5,  1'b0, 4'd1,  P_REST },  // R6 exit
        {4'd6,  4'd6,  1'b1, 4'd3,  P_REST },  // R7 ticks at rest
        {4'd2,  4'd6,  1'b1, 4'd2,  P_FALL },  // R7 ticks while falling
        {4'd2,  4'd2,  1'b1, 4'd1,  P_DWELL},  // R7 tick on entry edge not counted
        {4'd2,  4'd2,  1'b1, 4'd9,  P_DWELL},  // R7 nine counted ticks
        {4'd2,  4'd2,  1'b0, 4'd1,  P_DWELL},  // R7 still short of ten
        {4'd2,  4'd2,  1'b1, 4'd1,  P_DWELL},  // R6 tenth tick
        {4'd2,  4'd2,  1'b0, 4'd1,  P_REST },  // R6 exit
        {4'd7,  4'd8,  1'b0, 4'd1,  P_FALL }   // R10 adjacent floors
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [3:0] target_flr = '0;
    logic [3:0] cur_flr = '0;
    logic       move_up, move_dn, door_open, dwell_start;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    lift_car_ctrl #(.FLOOR_W(4), .DWELL_SEC(10)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_tick    (sec_tick),
        .target_flr  (target_flr),
        .cur_flr     (cur_flr),
        .move_up     (move_up),
        .move_dn     (move_dn),
        .door_open   (door_open),
        .dwell_start (dwell_start)
    );

    function automatic logic [3:0] pat();
        return {move_up, move_dn, door_open, dwell_start};
    endfunction

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic excl_chk();
        total++;
        if (door_open && (move_up || move_dn)) begin
            bad++;
            $display("FAIL R8: got %b expected door never with motion", pat());
        end
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(posedge clk);
        #5;
        chk("R1 reset pattern", pat(), P_REST);
        @(posedge clk);
        #2 rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            target_flr = VEC[i][16:13];
            cur_flr    = VEC[i][12:9];
            sec_tick   = VEC[i][8];
            for (int k = 0; k < int'(VEC[i][7:4]); k++) begin
                @(posedge clk);
                #2;
                chk($sformatf("R2 vector %0d edge %0d", i, k), pat(), VEC[i][3:0]);
                excl_chk();
            end
        end
        sec_tick = 1'b0;

        // R9: mid-cycle input change must not move the outputs
        target_flr = 4'd7;
        cur_flr    = 4'd7;
        @(posedge clk);
        #2;
        chk("R2 settle to dwell", pat(), P_DWELL);
        repeat (12) begin
            sec_tick = 1'b1;
            @(posedge clk);
            #2;
        end
        sec_tick = 1'b0;
        chk("R6 rest after dwell", pat(), P_REST);
        target_flr = 4'd12;
        cur_flr    = 4'd1;
        #5;
        chk("R9 no change between edges", pat(), P_REST);
        @(posedge clk);
        #2;
        chk("R3 rising after edge", pat(), P_RISE);

        // R1: asynchronous reset while moving
        #3 rst_n = 1'b0;
        #2;
        chk("R1 async reset mid-travel", pat(), P_REST);
        @(posedge clk);
        #2 rst_n = 1'b1;
        target_flr = 4'd0;
        cur_flr    = 4'd0;
        @(posedge clk);
        #2;
        chk("R1 rest after release", pat(), P_REST);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule